// File: doc/BRIEF.md
# Debug Mode Entry/Resume Controller

This block sits beside a hart's pipeline and decides when the hart stops for an external debugger and when it runs again. It watches halt requests from a debug module (plain, out-of-reset and halt-group), a trigger-fired strobe, an ebreak strobe, an instruction-retire strobe and a wait-stall flag from the core. When one or more halt reasons appear, it ranks them, records a three-bit reason code, and saves the privilege level, virtualization bit and PC the hart should continue from. While halted it masks interrupts and can freeze counters and the timer.

A debugger may rewrite the saved PC, privilege and virtualization bit while the hart is halted. On a resume request the controller releases the core, presents the saved values for the core to load, and tells the core to clear its modify-privilege bit when the restored level is below machine mode. With single-step enabled at resume, the hart runs one instruction or takes one trap and halts again. A halt request that arrives while a wait-for-interrupt style instruction is stalled first wakes the core, and entry happens once that instruction has completed.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: When several halt reasons are active in the same cycle, `cause_o` records the highest ranked one. The ranking, highest first, is reset-halt (code 5), halt group (6), halt request (3), trigger (2), ebreak (1), step (4).
- R2: A halt reason seen in cycle t sets `debug_mode_o`, `cause_o`, `prv_o`, `virt_o` and `dpc_o` from cycle t+1. `dpc_o` takes `pc_next_i`. `halted_o` is high for exactly that one cycle.
- R3: On entry for ebreak, `dpc_o` takes `ebreak_pc_i`, the ebreak's own address, and not `pc_next_i`.
- R4: Reset leaves `cause_o`=0, `prv_o`=3, `virt_o`=0 and `dpc_o`=0. In the first cycle after reset, `core_run_o` is 0. At the first edge, `rsthaltreq_i` gives entry with cause 5, `haltreq_i` alone gives cause 3, and with neither the core starts running.
- R5: While `wfi_stall_i` is high, a halt or group request does not enter debug mode and `stall_wake_o` is 1. Entry follows once the stall clears.
- R6: A resume with `step_i`=1 runs the core until the next `retire_i`, which covers both a retired instruction and a trap taken. That strobe enters debug mode with cause 4 and `dpc_o`=`pc_next_i`. A trigger in the same cycle makes the cause 2.
- R7: While stepping, a stalled wait instruction gets `stall_wake_o`=1 even with no halt request.
- R8: A resume request in cycle t, while halted, gives `resumed_o` high for one cycle at t+1, with `debug_mode_o`=0 and `core_run_o`=1. `mprv_clr_o` is high in that same cycle only if `prv_o` is not 3.
- R9: `irq_mask_o` (covering NMI) is 1 while halted and during the post-reset cycle. It is 0 while running, and during a step it equals the inverse of `stepie_i`.
- R10: `count_stop_o` equals `stopcount_i` and `time_stop_o` equals `stoptime_i` while in debug mode. Both are 0 otherwise.
- R11: While in debug mode, halt, trigger and ebreak inputs have no effect: `cause_o` and `dpc_o` keep their values and `halted_o` stays 0.
- R12: Debugger writes to `dpc_o`, `prv_o` and `virt_o` are applied only in debug mode. A written PC has bit 0 cleared. Privilege encodings are U=0, S=1, M=3. A write of 2, or of an unsupported level, becomes 3. `virt_o` is forced to 0 when the level is M or the virtualization option is off.
- R13: `rsthaltreq_i` is ignored outside the post-reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| haltreq_i | input | 1 | Halt request from the debug module |
| rsthaltreq_i | input | 1 | Halt-out-of-reset request |
| grphalt_i | input | 1 | Halt-group request |
| trig_fire_i | input | 1 | Trigger with debug action fired |
| ebreak_i | input | 1 | Ebreak reached, to enter debug |
| ebreak_pc_i | input | XLEN | Address of that ebreak |
| retire_i | input | 1 | Instruction retired or trap taken |
| pc_next_i | input | XLEN | Address of the next instruction to run |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Current virtualization bit |
| wfi_stall_i | input | 1 | Core stalled in a wait instruction |
| resume_req_i | input | 1 | Resume request |
| step_i | input | 1 | Single-step enable |
| stepie_i | input | 1 | Interrupts enabled while stepping |
| stopcount_i | input | 1 | Freeze counters while halted |
| stoptime_i | input | 1 | Freeze timer while halted |
| dpc_we_i | input | 1 | Debugger write of saved PC |
| dpc_wdata_i | input | XLEN | Saved PC write data |
| prv_we_i | input | 1 | Debugger write of privilege and virtualization |
| prv_wdata_i | input | 2 | Privilege write data |
| virt_wdata_i | input | 1 | Virtualization write data |
| core_run_o | output | 1 | Core may execute |
| debug_mode_o | output | 1 | Hart is halted in debug mode |
| halted_o | output | 1 | One-cycle pulse on entry |
| resumed_o | output | 1 | One-cycle pulse on exit; core loads saved state |
| stall_wake_o | output | 1 | End the current wait stall |
| irq_mask_o | output | 1 | Mask all interrupts including NMI |
| count_stop_o | output | 1 | Freeze hart counters |
| time_stop_o | output | 1 | Freeze timer |
| cause_o | output | 3 | Recorded halt reason |
| dpc_o | output | XLEN | Saved PC, resume address |
| prv_o | output | 2 | Saved privilege, restored on resume |
| virt_o | output | 1 | Saved virtualization bit, restored on resume |
| mprv_clr_o | output | 1 | Clear modify-privilege on this resume |

## Verification
The hardest case to reach is a halt request that lands on a stalled wait instruction. Entry must be held off while the stall is up, and must then happen on the completion cycle with the PC after the wait. The bench holds the stall and the request together for several edges and checks both the wake output and the absence of entry. It then drops the stall together with a retire strobe carrying a fresh PC. Stepping cases use a resume with step set followed by one retire. They are repeated with a trigger in the same cycle, with a handler address standing in for a trap, and with a stall, so the rank between step and trigger and the step wake are both seen at the ports.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_EBREAK    = 3'd1,
    CAUSE_TRIGGER   = 3'd2,
    CAUSE_HALTREQ   = 3'd3,
    CAUSE_STEP      = 3'd4,
    CAUSE_RESETHALT = 3'd5,
    CAUSE_GROUP     = 3'd6,
    CAUSE_OTHER     = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    ST_BOOT,
    ST_RUN,
    ST_STEP,
    ST_HALT
  } seq_state_e;

  // request vector is indexed by rank, 0 = highest
  localparam int NUM_CAUSES = 6;
  localparam int RK_RST  = 0;
  localparam int RK_GRP  = 1;
  localparam int RK_HALT = 2;
  localparam int RK_TRIG = 3;
  localparam int RK_EBRK = 4;
  localparam int RK_STEP = 5;

  function automatic cause_e rank_cause(int idx);
    case (idx)
      RK_RST:  return CAUSE_RESETHALT;
      RK_GRP:  return CAUSE_GROUP;
      RK_HALT: return CAUSE_HALTREQ;
      RK_TRIG: return CAUSE_TRIGGER;
      RK_EBRK: return CAUSE_EBREAK;
      RK_STEP: return CAUSE_STEP;
      default: return CAUSE_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb
  import dbg_ctrl_pkg::*;
#(
  parameter int N = NUM_CAUSES
) (
  input  logic [N-1:0] req_i,
  output logic         valid_o,
  output cause_e       cause_o,
  output logic [N-1:0] grant_o
);

  // scan from lowest rank up so the highest ranked request is left standing
  always_comb begin
    cause_o = CAUSE_NONE;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        cause_o    = rank_cause(i);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end

  assign valid_o = |req_i;

endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enter_i,
  input  logic       resume_req_i,
  input  logic       step_i,
  output seq_state_e state_o,
  output logic       halted_o,
  output logic       resumed_o
);

  seq_state_e state_q, state_d;
  logic       halted_q, resumed_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_BOOT: state_d = enter_i ? ST_HALT : ST_RUN;
      ST_RUN,
      ST_STEP: if (enter_i) state_d = ST_HALT;
      ST_HALT: if (resume_req_i) state_d = step_i ? ST_STEP : ST_RUN;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_BOOT;
      halted_q  <= 1'b0;
      resumed_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      halted_q  <= enter_i && (state_q != ST_HALT);
      resumed_q <= resume_req_i && (state_q == ST_HALT);
    end
  end

  assign state_o   = state_q;
  assign halted_o  = halted_q;
  assign resumed_o = resumed_q;

  p_halted_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> !halted_q);
  p_halted_in_debug_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |-> state_q == ST_HALT);
  p_resumed_running_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resumed_q |-> (state_q == ST_RUN || state_q == ST_STEP));
  p_boot_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_BOOT |=> state_q != ST_BOOT);

endmodule

// File: rtl/dbg_save_regs.sv
module dbg_save_regs
  import dbg_ctrl_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_H = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            capture_i,
  input  cause_e          cause_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            wr_en_i,
  input  logic            dpc_we_i,
  input  logic [XLEN-1:0] dpc_wdata_i,
  input  logic            prv_we_i,
  input  logic [1:0]      prv_wdata_i,
  input  logic            virt_wdata_i,
  output cause_e          cause_o,
  output priv_e           prv_o,
  output logic            virt_o,
  output logic [XLEN-1:0] dpc_o
);

  cause_e          cause_q;
  priv_e           prv_q;
  logic            virt_q;
  logic [XLEN-1:0] dpc_q;

  function automatic priv_e legal_priv(logic [1:0] p);
    case (p)
      2'd0:    return HAS_U ? PRIV_U : PRIV_M;
      2'd1:    return HAS_S ? PRIV_S : PRIV_M;
      default: return PRIV_M;
    endcase
  endfunction

  function automatic logic legal_virt(priv_e p, logic v);
    return HAS_H && (p != PRIV_M) && v;
  endfunction

  priv_e cap_prv, wr_prv;
  assign cap_prv = legal_priv(priv_i);
  assign wr_prv  = legal_priv(prv_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= CAUSE_NONE;
      prv_q   <= PRIV_M;
      virt_q  <= 1'b0;
      dpc_q   <= '0;
    end else if (capture_i) begin
      cause_q <= cause_i;
      prv_q   <= cap_prv;
      virt_q  <= legal_virt(cap_prv, virt_i);
      dpc_q   <= pc_i;
    end else if (wr_en_i) begin
      if (dpc_we_i) dpc_q <= {dpc_wdata_i[XLEN-1:1], 1'b0};
      if (prv_we_i) begin
        prv_q  <= wr_prv;
        virt_q <= legal_virt(wr_prv, virt_wdata_i);
      end
    end
  end

  assign cause_o = cause_q;
  assign prv_o   = prv_q;
  assign virt_o  = virt_q;
  assign dpc_o   = dpc_q;

  p_prv_legal_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prv_q != PRIV_RSVD);
  p_virt_m_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prv_q == PRIV_M |-> !virt_q);
  p_dpc_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && !(wr_en_i && dpc_we_i)) |=> $stable(dpc_q));

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_ctrl_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter bit HAS_S = 1'b1,
  parameter bit HAS_U = 1'b1,
  parameter bit HAS_H = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            haltreq_i,
  input  logic            rsthaltreq_i,
  input  logic            grphalt_i,
  input  logic            trig_fire_i,
  input  logic            ebreak_i,
  input  logic [XLEN-1:0] ebreak_pc_i,
  input  logic            retire_i,
  input  logic [XLEN-1:0] pc_next_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic            wfi_stall_i,
  input  logic            resume_req_i,
  input  logic            step_i,
  input  logic            stepie_i,
  input  logic            stopcount_i,
  input  logic            stoptime_i,
  input  logic            dpc_we_i,
  input  logic [XLEN-1:0] dpc_wdata_i,
  input  logic            prv_we_i,
  input  logic [1:0]      prv_wdata_i,
  input  logic            virt_wdata_i,
  output logic            core_run_o,
  output logic            debug_mode_o,
  output logic            halted_o,
  output logic            resumed_o,
  output logic            stall_wake_o,
  output logic            irq_mask_o,
  output logic            count_stop_o,
  output logic            time_stop_o,
  output logic [2:0]      cause_o,
  output logic [XLEN-1:0] dpc_o,
  output logic [1:0]      prv_o,
  output logic            virt_o,
  output logic            mprv_clr_o
);

  seq_state_e            state;
  logic                  in_boot, running, stepping, in_debug;
  logic [NUM_CAUSES-1:0] req, grant;
  logic                  enter;
  cause_e                win_cause, saved_cause;
  priv_e                 saved_prv;
  logic [XLEN-1:0]       entry_pc;

  assign in_boot  = (state == ST_BOOT);
  assign stepping = (state == ST_STEP);
  assign running  = (state == ST_RUN) || stepping;
  assign in_debug = (state == ST_HALT);

  // halt reasons, by rank; external requests wait while a wait instruction stalls
  assign req[RK_RST]  = in_boot && rsthaltreq_i;
  assign req[RK_GRP]  = running && grphalt_i && !wfi_stall_i;
  assign req[RK_HALT] = haltreq_i && (in_boot || (running && !wfi_stall_i));
  assign req[RK_TRIG] = running && trig_fire_i;
  assign req[RK_EBRK] = running && ebreak_i;
  assign req[RK_STEP] = stepping && retire_i;

  dbg_cause_arb #(.N(NUM_CAUSES)) i_arb (
    .req_i   (req),
    .valid_o (enter),
    .cause_o (win_cause),
    .grant_o (grant)
  );

  assign entry_pc = grant[RK_EBRK] ? ebreak_pc_i : pc_next_i;

  dbg_seq i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enter_i      (enter),
    .resume_req_i (resume_req_i),
    .step_i       (step_i),
    .state_o      (state),
    .halted_o     (halted_o),
    .resumed_o    (resumed_o)
  );

  dbg_save_regs #(
    .XLEN  (XLEN),
    .HAS_S (HAS_S),
    .HAS_U (HAS_U),
    .HAS_H (HAS_H)
  ) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .capture_i    (enter),
    .cause_i      (win_cause),
    .priv_i       (priv_i),
    .virt_i       (virt_i),
    .pc_i         (entry_pc),
    .wr_en_i      (in_debug),
    .dpc_we_i     (dpc_we_i),
    .dpc_wdata_i  (dpc_wdata_i),
    .prv_we_i     (prv_we_i),
    .prv_wdata_i  (prv_wdata_i),
    .virt_wdata_i (virt_wdata_i),
    .cause_o      (saved_cause),
    .prv_o        (saved_prv),
    .virt_o       (virt_o),
    .dpc_o        (dpc_o)
  );

  assign cause_o      = saved_cause;
  assign prv_o        = saved_prv;
  assign core_run_o   = running;
  assign debug_mode_o = in_debug;
  assign stall_wake_o = running && wfi_stall_i && (haltreq_i || grphalt_i || stepping);
  assign irq_mask_o   = !running || (stepping && !stepie_i);
  assign count_stop_o = in_debug && stopcount_i;
  assign time_stop_o  = in_debug && stoptime_i;
  assign mprv_clr_o   = resumed_o && (saved_prv != PRIV_M);

  p_grant_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (enter == (grant != '0)));
  p_rst_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req[RK_RST] |-> win_cause == CAUSE_RESETHALT);
  p_step_lowest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant[RK_STEP] |-> req[RK_EBRK:RK_RST] == '0);
  p_ignore_in_debug_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_debug && !resume_req_i) |=> $stable(saved_cause) && !halted_o);
  p_mprv_on_resume_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mprv_clr_o |-> resumed_o && !debug_mode_o);
  p_wake_stalled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_wake_o |-> !enter || req[RK_TRIG] || req[RK_EBRK]);

endmodule

// File: tb/test_dbg_mode_ctrl.sv
`timescale 1ns/1ps
module test_dbg_mode_ctrl;
  localparam int XLEN = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic haltreq, rsthaltreq, grphalt, trig, ebrk, retire, virt, stall, resume;
  logic step, stepie, stopcount, stoptime, dpc_we, prv_we, virt_wd;
  logic [XLEN-1:0] ebrk_pc, pc_next, dpc_wd;
  logic [1:0] priv, prv_wd;
  logic core_run, dmode, halted, resumed, wake, irq_mask, cstop, tstop, virt_o, mprv_clr;
  logic [2:0] cause;
  logic [XLEN-1:0] dpc;
  logic [1:0] prv;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_mode_ctrl #(.XLEN(XLEN)) i_dbg_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .haltreq_i(haltreq), .rsthaltreq_i(rsthaltreq),
    .grphalt_i(grphalt), .trig_fire_i(trig), .ebreak_i(ebrk), .ebreak_pc_i(ebrk_pc),
    .retire_i(retire), .pc_next_i(pc_next), .priv_i(priv), .virt_i(virt),
    .wfi_stall_i(stall), .resume_req_i(resume), .step_i(step), .stepie_i(stepie),
    .stopcount_i(stopcount), .stoptime_i(stoptime), .dpc_we_i(dpc_we),
    .dpc_wdata_i(dpc_wd), .prv_we_i(prv_we), .prv_wdata_i(prv_wd),
    .virt_wdata_i(virt_wd), .core_run_o(core_run), .debug_mode_o(dmode),
    .halted_o(halted), .resumed_o(resumed), .stall_wake_o(wake),
    .irq_mask_o(irq_mask), .count_stop_o(cstop), .time_stop_o(tstop),
    .cause_o(cause), .dpc_o(dpc), .prv_o(prv), .virt_o(virt_o), .mprv_clr_o(mprv_clr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs();
    haltreq = 0; rsthaltreq = 0; grphalt = 0; trig = 0; ebrk = 0; retire = 0;
    stall = 0; resume = 0; dpc_we = 0; prv_we = 0;
  endtask

  task automatic do_reset(input logic rh, input logic h);
    @(negedge clk);
    rst_ni = 0; clear_reqs(); rsthaltreq = rh; haltreq = h;
    step = 0; stepie = 0; stopcount = 0; stoptime = 0;
    pc_next = 32'h8000_0000; ebrk_pc = 0; priv = 2'd3; virt = 0;
    dpc_wd = 0; prv_wd = 0; virt_wd = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
  endtask

  // drive requests at a negedge, let one edge capture them, then drop them
  task automatic pulse(input logic h, input logic g, input logic t, input logic e,
                       input logic r, input logic rh);
    @(negedge clk);
    haltreq = h; grphalt = g; trig = t; ebrk = e; retire = r; rsthaltreq = rh;
    @(posedge clk); #1;
    clear_reqs();
  endtask

  task automatic do_resume(input logic s);
    @(negedge clk);
    resume = 1; step = s;
    @(posedge clk); #1;
    resume = 0;
  endtask

  task automatic t_boot_resethalt();
    do_reset(1, 1);
    chk("R4 reset cause", cause, 0);
    chk("R4 reset prv", prv, 3);
    chk("R4 reset dpc", dpc, 0);
    chk("R4 no run before first edge", core_run, 0);
    chk("R9 mask in boot cycle", irq_mask, 1);
    @(posedge clk); #1;
    clear_reqs();
    chk("R4 enter from reset", dmode, 1);
    chk("R1 resethalt over halt", cause, 5);
    chk("R2 halted pulse", halted, 1);
    chk("R2 dpc reset vector", dpc, 32'h8000_0000);
    @(posedge clk); #1;
    chk("R2 halted one cycle", halted, 0);
  endtask

  task automatic t_boot_halt_and_plain();
    do_reset(0, 1);
    @(posedge clk); #1;
    clear_reqs();
    chk("R4 halt at boot cause", cause, 3);
    chk("R4 halt at boot mode", dmode, 1);
    do_reset(0, 0);
    stopcount = 1; stoptime = 1;
    @(posedge clk); #1;
    chk("R4 plain boot runs", core_run, 1);
    chk("R4 plain boot not halted", dmode, 0);
    chk("R9 mask off running", irq_mask, 0);
    chk("R10 count runs outside debug", cstop, 0);
    chk("R10 time runs outside debug", tstop, 0);
    stopcount = 0; stoptime = 0;
  endtask

  task automatic t_run_ignores();
    pulse(0, 0, 0, 0, 0, 1);
    chk("R13 resethalt ignored in run", dmode, 0);
    @(negedge clk);
    dpc_we = 1; dpc_wd = 32'h5555_0000;
    @(posedge clk); #1;
    dpc_we = 0;
    chk("R12 dpc write ignored in run", dpc, 32'h0);
  endtask

  task automatic t_priority();
    priv = 2'd1; virt = 1; pc_next = 32'h100;
    pulse(1, 1, 1, 1, 0, 0);
    chk("R1 group highest", cause, 6);
    chk("R2 prv captured", prv, 1);
    chk("R2 virt captured", virt_o, 1);
    chk("R2 dpc next pc", dpc, 32'h100);
    priv = 2'd3; virt = 0;
    do_resume(0);
    chk("R8 mprv clear below M", mprv_clr, 1);
    chk("R8 resumed pulse", resumed, 1);
    pc_next = 32'h200;
    pulse(1, 0, 1, 1, 0, 0);
    chk("R1 halt over trigger", cause, 3);
    do_resume(0);
    chk("R8 no mprv clear at M", mprv_clr, 0);
    @(posedge clk); #1;
    chk("R8 resumed one cycle", resumed, 0);
    pc_next = 32'h300; ebrk_pc = 32'h2fc;
    pulse(0, 0, 1, 1, 0, 0);
    chk("R1 trigger over ebreak", cause, 2);
    chk("R2 trigger dpc", dpc, 32'h300);
    do_resume(0);
    pulse(0, 0, 0, 1, 0, 0);
    chk("R1 ebreak cause", cause, 1);
    chk("R3 ebreak own address", dpc, 32'h2fc);
  endtask

  task automatic t_debug_ignores();
    stopcount = 1; stoptime = 0;
    #1;
    chk("R9 mask in debug", irq_mask, 1);
    chk("R10 counters frozen", cstop, 1);
    chk("R10 timer runs", tstop, 0);
    stopcount = 0; stoptime = 1;
    #1;
    chk("R10 timer frozen", tstop, 1);
    stoptime = 0;
    pc_next = 32'h900; ebrk_pc = 32'h904;
    pulse(1, 1, 1, 1, 0, 0);
    chk("R11 cause kept", cause, 1);
    chk("R11 dpc kept", dpc, 32'h2fc);
    chk("R11 no halted pulse", halted, 0);
  endtask

  task automatic t_writes();
    @(negedge clk);
    dpc_we = 1; dpc_wd = 32'h1235; prv_we = 1; prv_wd = 2'd2; virt_wd = 1;
    @(posedge clk); #1;
    clear_reqs();
    chk("R12 dpc bit0 cleared", dpc, 32'h1234);
    chk("R12 reserved prv to M", prv, 3);
    chk("R12 virt zero at M", virt_o, 0);
    @(negedge clk);
    prv_we = 1; prv_wd = 2'd0; virt_wd = 1;
    @(posedge clk); #1;
    clear_reqs();
    chk("R12 prv U written", prv, 0);
    chk("R12 virt written", virt_o, 1);
    do_resume(0);
    chk("R8 leaves debug", dmode, 0);
    chk("R8 core runs", core_run, 1);
    chk("R8 mprv clear for U", mprv_clr, 1);
    chk("R8 resume pc", dpc, 32'h1234);
  endtask

  task automatic t_stall_halt();
    @(negedge clk);
    stall = 1; haltreq = 1;
    #1;
    chk("R5 wake on halt", wake, 1);
    repeat (2) @(posedge clk);
    #1;
    chk("R5 no entry while stalled", dmode, 0);
    @(negedge clk);
    stall = 0; retire = 1; pc_next = 32'h504;
    @(posedge clk); #1;
    clear_reqs();
    chk("R5 entry after stall", dmode, 1);
    chk("R5 cause halt", cause, 3);
    chk("R5 dpc after wait", dpc, 32'h504);
  endtask

  task automatic t_step();
    do_resume(1);
    chk("R6 step runs", core_run, 1);
    chk("R9 mask during step", irq_mask, 1);
    pulse(0, 0, 0, 0, 1, 0);
    chk("R6 step reentry", dmode, 1);
    chk("R6 step cause", cause, 4);
    chk("R6 step dpc", dpc, 32'h504);
    stepie = 1;
    do_resume(1);
    chk("R9 step irq enabled", irq_mask, 0);
    pc_next = 32'h600;
    pulse(0, 0, 1, 0, 1, 0);
    chk("R6 trigger over step", cause, 2);
    chk("R6 trigger step dpc", dpc, 32'h600);
    stepie = 0;
    do_resume(1);
    pc_next = 32'h40;
    pulse(0, 0, 0, 0, 1, 0);
    chk("R6 trap step cause", cause, 4);
    chk("R6 trap handler dpc", dpc, 32'h40);
    chk("R6 no handler execution", core_run, 0);
    do_resume(1);
    @(negedge clk);
    stall = 1;
    #1;
    chk("R7 stepped wait woken", wake, 1);
    @(posedge clk); #1;
    chk("R7 no entry while stalled", dmode, 0);
    @(negedge clk);
    stall = 0; retire = 1; pc_next = 32'h44;
    @(posedge clk); #1;
    clear_reqs();
    chk("R7 step after wake", cause, 4);
    chk("R7 dpc after wake", dpc, 32'h44);
    step = 0;
  endtask

  initial begin
    clear_reqs();
    t_boot_resethalt();
    t_boot_halt_and_plain();
    t_run_ignores();
    t_priority();
    t_debug_ignores();
    t_writes();
    t_stall_halt();
    t_step();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule